// File: doc/BRIEF.md
# Interpolated Cosine Generator

This block turns a phase into a signed fixed-point cosine using only integer hardware. The phase is an unsigned fraction of one full turn, so adding to it and letting it overflow wraps the angle with no extra logic. The upper phase bits select one of a set of coarse cosine samples. A second table holds, for each coarse entry, the step to the next sample. The lower phase bits scale that step in one multiply, and a single adder joins the scaled step to the sample. The result is linear interpolation between the coarse points.

Both tables are constant arrays computed when the design is elaborated, so no initialisation file is involved. Phases enter and results leave through a valid/ready pipeline with three register stages. One phase is accepted per cycle whenever the output side is not stalled. A typical use is a numerically controlled oscillator: a phase accumulator feeds the input, and the output drives a mixer or a digital-to-analogue converter.

Top module: `cos_interp_gen`

## Requirements
- R1: During and directly after the active-low synchronous reset, out_valid is 0 and in_ready is 1.
- R2: The 16-bit phase is in turns. Bits [15:8] form the coarse index k and bits [7:0] form the fraction f. The sample table holds s_k = round(32768*cos(2*pi*k/256)), with halves rounded away from zero and the value clamped to 32767.
- R3: The slope entry is d_k = s_((k+1) mod 256) - s_k, so entry 255 takes its slope toward entry 0.
- R4: out_cos equals s_k + ((d_k*f + 128) >>> 8), using an arithmetic shift, saturated to the range -32768..32767, in signed two's complement.
- R5: For every phase, out_cos lies within 4 LSB of 32768*cos(2*pi*phase/65536). The 32767 clamp near phase 0 counts toward this margin.
- R6: A phase accepted while the output side is not stalled appears on out_cos with out_valid exactly 3 cycles later. With out_ready held at 1, one result leaves per cycle.
- R7: While out_valid is 1 and out_ready is 0, out_cos and out_valid hold their values and in_ready is 0. No result is lost or duplicated under backpressure.
- R8: Phases with f = 0 return the stored sample exactly: 0x0000 gives 32767, 0x4000 gives 0, 0x8000 gives -32768 and 0xC000 gives 0.
- R9: Phases 0xFF01..0xFFFF interpolate between entry 255 and entry 0 and rise toward 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Phase on in_phase is offered |
| in_ready | output | 1 | Block accepts a phase this cycle |
| in_phase | input | 16 | Phase in turns, unsigned |
| out_valid | output | 1 | out_cos holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_cos | output | 16 | Cosine, signed Q1.15 |

## Verification
The bench sweeps all 65536 phases and compares each result both against the exact integer rule and against a real-valued cosine. The sweep catches three kinds of fault: a slope that does not wrap, which corrupts the top 255 phases; a truncating shift where a rounding one belongs, which biases negative corrections by one; and a missing clamp, which wraps cos(0) to -32768. Directed cases hit the four quadrant points, measure the three-cycle latency, and run a random backpressure segment. A pipeline that ignored stalls would drop or repeat results, and the in-order comparison of that segment shows it.

// File: rtl/cos_interp_pkg.sv
// Package: shared widths and the elaboration-time cosine sample function.
// Assumes real arithmetic is available in constant functions.
package cos_interp_pkg;

    localparam int PHASE_BITS = 16;
    localparam int INDEX_BITS = 8;
    localparam int RESULT_BITS = 16;
    localparam int STEP_BITS = 17;

    // Cosine of 2*pi*k/depth scaled to 2^(width-1), rounded away from zero,
    // clamped to the largest positive code.
    function automatic int cos_code(input int k, input int depth, input int width);
        real pi_c;
        real x;
        real term;
        real acc;
        real scaled;
        int  code;
        int  top;
        pi_c = 3.14159265358979323846;
        x = 2.0 * pi_c * real'(k) / real'(depth);
        if (x > pi_c) x = x - 2.0 * pi_c;
        term = 1.0;
        acc = 1.0;
        for (int n = 1; n < 30; n++) begin
            term = -term * x * x / (real'(2 * n - 1) * real'(2 * n));
            acc = acc + term;
        end
        scaled = acc * real'(1 << (width - 1));
        if (scaled >= 0.0) code = $rtoi(scaled + 0.5);
        else code = -$rtoi(-scaled + 0.5);
        top = (1 << (width - 1)) - 1;
        if (code > top) code = top;
        return code;
    endfunction

endpackage

// File: rtl/cos_table_stage.sv
// Stage 1: holds the constant sample and step tables, registers the selected
// entries together with the fraction bits. Assumes PH_W > IDX_W.
module cos_table_stage #(
    parameter int PH_W  = 16,
    parameter int IDX_W = 8,
    parameter int OUT_W = 16,
    parameter int SLP_W = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    vld_in,
    input  logic [PH_W-1:0]         phase,
    output logic                    vld_q,
    output logic signed [OUT_W-1:0] smp_q,
    output logic signed [SLP_W-1:0] slp_q,
    output logic [PH_W-IDX_W-1:0]   frac_q
);
    import cos_interp_pkg::*;

    localparam int DEPTH  = 1 << IDX_W;
    localparam int FRAC_W = PH_W - IDX_W;

    logic signed [OUT_W-1:0] smp_tab [DEPTH];
    logic signed [SLP_W-1:0] slp_tab [DEPTH];
    logic [IDX_W-1:0]        idx;

    assign idx = phase[PH_W-1:FRAC_W];

    // Build one sample and one wrapping step per coarse entry.
    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        localparam int SC = cos_code(k, DEPTH, OUT_W);
        localparam int SN = cos_code((k + 1) % DEPTH, DEPTH, OUT_W);
        assign smp_tab[k] = OUT_W'(SC);
        assign slp_tab[k] = SLP_W'(SN - SC);
    end

    // Register the looked-up entries while the pipe advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            smp_q  <= '0;
            slp_q  <= '0;
            frac_q <= '0;
        end else if (en) begin
            vld_q  <= vld_in;
            smp_q  <= smp_tab[idx];
            slp_q  <= slp_tab[idx];
            frac_q <= phase[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/cos_mul_stage.sv
// Stage 2: multiplies the signed step by the unsigned fraction and passes the
// sample along. Assumes PRD_W >= SLP_W + FRAC_W + 1.
module cos_mul_stage #(
    parameter int FRAC_W = 8,
    parameter int OUT_W  = 16,
    parameter int SLP_W  = 17,
    parameter int PRD_W  = SLP_W + FRAC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    vld_in,
    input  logic signed [OUT_W-1:0] smp_in,
    input  logic signed [SLP_W-1:0] slp_in,
    input  logic [FRAC_W-1:0]       frac_in,
    output logic                    vld_q,
    output logic signed [OUT_W-1:0] smp_q,
    output logic signed [PRD_W-1:0] prd_q
);
    logic signed [PRD_W-1:0] a_ext;
    logic signed [PRD_W-1:0] b_ext;
    logic signed [PRD_W-1:0] prd;

    // Widen both operands, keeping the fraction non-negative.
    always_comb begin
        a_ext = PRD_W'(slp_in);
        b_ext = PRD_W'({1'b0, frac_in});
        prd   = a_ext * b_ext;
    end

    // Register the product beside its sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            smp_q <= '0;
            prd_q <= '0;
        end else if (en) begin
            vld_q <= vld_in;
            smp_q <= smp_in;
            prd_q <= prd;
        end
    end
endmodule

// File: rtl/cos_add_stage.sv
// Stage 3: rounds the product back to output scale, adds it to the sample and
// saturates to the signed output range.
module cos_add_stage #(
    parameter int FRAC_W = 8,
    parameter int OUT_W  = 16,
    parameter int PRD_W  = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    vld_in,
    input  logic signed [OUT_W-1:0] smp_in,
    input  logic signed [PRD_W-1:0] prd_in,
    output logic                    vld_q,
    output logic signed [OUT_W-1:0] res_q
);
    localparam logic signed [PRD_W-1:0] HALF  = PRD_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [PRD_W-1:0] MAXV  = PRD_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [PRD_W-1:0] MINV  = -PRD_W'(1 << (OUT_W - 1));

    logic signed [PRD_W-1:0] corr;
    logic signed [PRD_W-1:0] total;
    logic signed [OUT_W-1:0] clipped;

    // Round half up, add, then clip.
    always_comb begin
        corr  = (prd_in + HALF) >>> FRAC_W;
        total = PRD_W'(smp_in) + corr;
        if (total > MAXV)      clipped = MAXV[OUT_W-1:0];
        else if (total < MINV) clipped = MINV[OUT_W-1:0];
        else                   clipped = total[OUT_W-1:0];
    end

    // Register the final result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else if (en) begin
            vld_q <= vld_in;
            res_q <= clipped;
        end
    end
endmodule

// File: rtl/cos_interp_gen.sv
// Top: phase-to-cosine pipeline of three stages under one stall enable.
// The whole pipe advances when the output is empty or being taken.
module cos_interp_gen #(
    parameter int PH_W  = cos_interp_pkg::PHASE_BITS,
    parameter int IDX_W = cos_interp_pkg::INDEX_BITS,
    parameter int OUT_W = cos_interp_pkg::RESULT_BITS,
    parameter int SLP_W = cos_interp_pkg::STEP_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PH_W-1:0]  in_phase,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_cos
);
    localparam int FRAC_W = PH_W - IDX_W;
    localparam int PRD_W  = SLP_W + FRAC_W + 1;

    logic                    adv;
    logic                    v1, v2, v3;
    logic signed [OUT_W-1:0] smp1, smp2, res3;
    logic signed [SLP_W-1:0] slp1;
    logic [FRAC_W-1:0]       frac1;
    logic signed [PRD_W-1:0] prd2;

    // Pipe advances unless a held result is refused.
    assign adv      = !v3 || out_ready;
    assign in_ready = adv;

    cos_table_stage #(.PH_W(PH_W), .IDX_W(IDX_W), .OUT_W(OUT_W), .SLP_W(SLP_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .en(adv), .vld_in(in_valid), .phase(in_phase),
        .vld_q(v1), .smp_q(smp1), .slp_q(slp1), .frac_q(frac1)
    );

    cos_mul_stage #(.FRAC_W(FRAC_W), .OUT_W(OUT_W), .SLP_W(SLP_W), .PRD_W(PRD_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .en(adv), .vld_in(v1), .smp_in(smp1),
        .slp_in(slp1), .frac_in(frac1), .vld_q(v2), .smp_q(smp2), .prd_q(prd2)
    );

    cos_add_stage #(.FRAC_W(FRAC_W), .OUT_W(OUT_W), .PRD_W(PRD_W)) u_add (
        .clk(clk), .rst_n(rst_n), .en(adv), .vld_in(v2), .smp_in(smp2),
        .prd_in(prd2), .vld_q(v3), .res_q(res3)
    );

    assign out_valid = v3;
    assign out_cos   = res3;
endmodule

// File: rtl/cos_interp_chk.sv
// Checker: protocol and timing properties of cos_interp_gen, bound below.
module cos_interp_chk #(
    parameter int PH_W  = 16,
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PH_W-1:0]  in_phase,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_cos
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && in_ready);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_cos)));

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(in_valid && in_ready, 3) && $past(out_ready, 1)
         && $past(out_ready, 2) && $past(rst_n, 1) && $past(rst_n, 2)) |-> out_valid);

    // R4
    known_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_cos));
endmodule

bind cos_interp_gen cos_interp_chk #(.PH_W(PH_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready), .out_cos(out_cos)
);

// File: tb/test_cos_interp_gen.sv
module test_cos_interp_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_phase = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_cos;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    logic [15:0] pend[$];

    localparam real PI = 3.14159265358979323846;
    localparam int NV = 12;
    localparam logic [15:0] VEC_PH [NV] = '{16'h0000, 16'h0001, 16'h0080, 16'h00FF,
        16'h2A55, 16'h4000, 16'h5F80, 16'h8000, 16'h9C3D, 16'hC000, 16'hFF80, 16'hFFFF};

    always #4 clk = ~clk;

    cos_interp_gen i_cos_interp_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready), .out_cos(out_cos)
    );

    function automatic int smp(input int k);
        real v;
        int  r;
        v = 32768.0 * $cos(2.0 * PI * real'(k) / 256.0);
        if (v >= 0.0) r = $rtoi(v + 0.5);
        else r = -$rtoi(-v + 0.5);
        if (r > 32767) r = 32767;
        return r;
    endfunction

    // R2 R3 R4 rule
    function automatic int model(input logic [15:0] ph);
        int k;
        int f;
        int d;
        int r;
        k = int'(ph[15:8]);
        f = int'(ph[7:0]);
        d = smp((k + 1) % 256) - smp(k);
        r = smp(k) + ((d * f + 128) >>> 8);
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_out(input logic [15:0] ph);
        int act;
        int ideal;
        int err;
        act = int'($signed(out_cos));
        check("R4", act, model(ph));
        ideal = $rtoi(32768.0 * $cos(2.0 * PI * real'(ph) / 65536.0)
                      + (($cos(2.0 * PI * real'(ph) / 65536.0) >= 0.0) ? 0.5 : -0.5));
        err = act - ideal;
        if (err < 0) err = -err;
        check("R5", (err <= 4) ? 1 : 0, 1);
    endtask

    // One cycle: drive at the falling edge, then record the two handshakes.
    task automatic step(input bit iv, input logic [15:0] ph, input bit ordy);
        logic [15:0] p;
        @(negedge clk);
        in_valid  = iv;
        in_phase  = ph;
        out_ready = ordy;
        #1;
        if (out_valid && out_ready) begin
            if (pend.size() == 0) check("R7", 1, 0);
            else begin
                p = pend.pop_front();
                check_out(p);
            end
        end
        if (in_valid && in_ready) pend.push_back(in_phase);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected<150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(out_valid), 0);
        check("R1", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0);

        // R6: single phase latency
        in_valid = 1'b1;
        in_phase = 16'h4000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6", int'(out_valid), 0);
        @(negedge clk);
        check("R6", int'(out_valid), 0);
        @(negedge clk);
        check("R6", int'(out_valid), 1);
        check("R8", int'($signed(out_cos)), 0);
        @(negedge clk);
        check("R6", int'(out_valid), 0);

        // Vector table
        for (int i = 0; i < NV; i++) step(1'b1, VEC_PH[i], 1'b1);
        repeat (4) step(1'b0, 16'h0, 1'b1);

        // R8: exact table points
        check("R8", model(16'h0000), 32767);
        check("R8", model(16'h8000), -32768);
        check("R8", model(16'hC000), 0);

        // R9: wrap from entry 255 to entry 0
        step(1'b1, 16'hFFFF, 1'b1);
        repeat (3) step(1'b0, 16'h0, 1'b0);
        check("R9", (int'($signed(out_cos)) >= smp(255)) ? 1 : 0, 1);
        check("R9", int'($signed(out_cos)), model(16'hFFFF));
        step(1'b0, 16'h0, 1'b1);
        pend.delete();

        // R7: random backpressure, in-order results and held output
        begin
            logic [15:0] held;
            bit          was_stall;
            was_stall = 0;
            held = '0;
            for (int i = 0; i < 3000; i++) begin
                if (was_stall) begin
                    check("R7", int'(out_valid), 1);
                    check("R7", int'(out_cos), int'(held));
                end
                step(1'($urandom_range(0, 1)), 16'($urandom()), 1'($urandom_range(0, 2) != 0));
                was_stall = out_valid && !out_ready;
                held = out_cos;
            end
            repeat (6) step(1'b0, 16'h0, 1'b1);
            check("R7", pend.size(), 0);
        end

        // R5 R4 R6: full sweep at one phase per cycle
        for (int p = 0; p < 65536; p++) begin
            step(1'b1, 16'(p), 1'b1);
            if (!in_ready) check("R6", 0, 1);
        end
        repeat (5) step(1'b0, 16'h0, 1'b1);
        check("R6", pend.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule